// File: doc/BRIEF.md
# Bidirectional Thermal Throttle Controller

This block decides when a shared, active-low "hot" line is pulled low, and when the local throttling logic is turned on. The line is open-drain and has two roles. The die pulls it low to report that its own sensor has reached the maximum safe temperature. Any agent on the board can also pull it low to force this die to throttle.

The block takes three inputs: the on-die over-temperature flag, a software enable for throttling, and the raw level of the line. The raw level is asynchronous and passes through a synchronizer before use. The block drives two things:
- a pull-down enable for the pad;
- a throttle-active signal for the clock or performance reduction logic downstream.

When the line is low only because the block is pulling it low, the block does not count that as an external request. A status bit reports whether the most recent throttle activation came from the sensor or from outside.

Top module: `thermal_throttle`

## Requirements
- R1: After reset, `hot_drive_o` is 0, `throttle_o` is 0 and `cause_ext_o` is 0.
- R2: `hot_drive_o` equals `sensor_hot_i` as sampled at the previous clock edge, whatever `tcc_enable_i` is.
- R3: With `tcc_enable_i` = 1, `throttle_o` rises one clock after `hot_drive_o` rises. It falls one clock after `hot_drive_o` falls, unless an external request is latched.
- R4: `hot_line_i` is active-low: 0 means asserted. The line passes through a two-flop synchronizer. With enable set and the block not driving, `throttle_o` rises on the third clock edge after the line goes low.
- R5: Once externally triggered, throttling stays on for as long as the line stays low. It ends on the third clock edge after the line returns high.
- R6: While `tcc_enable_i` is 0, `throttle_o` is 0 one clock later, whatever the cause. This includes an external request that was already latched, which is dropped.
- R7: The line being low because of the block's own drive, including the two synchronizer cycles after the drive is released, never starts external throttling.
- R8: `cause_ext_o` loads only on the clock where `throttle_o` rises. It loads 0 (internal) if the block is driving the line at that point, and 1 (external) otherwise. At all other times it holds its value.
- R9: While an external request is latched, the block's own drive starting or stopping does not end throttling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sensor_hot_i | input | 1 | On-die sensor reports maximum safe temperature |
| tcc_enable_i | input | 1 | Software enable for throttling |
| hot_line_i | input | 1 | Raw level of the shared active-low hot line |
| hot_drive_o | output | 1 | Pull the hot line low |
| throttle_o | output | 1 | Throttling active |
| cause_ext_o | output | 1 | Last activation source: 0 internal, 1 external |

## Verification
The assertions check the following on every cycle:
- the pad drive tracks the sensor one cycle later (R2);
- there is never throttling without the enable (R6);
- the external latch is released once the synchronized line is high (R5);
- the latch never captures while the self-drive mask is active (R7);
- the source bit changes only when throttling starts (R8).

Only the bench's scenarios can show the exact latencies through the synchronizer on entry and exit (R4, R5). The same applies to the absence of a false external event after the block releases its own drive, and to throttling continuing when the sensor pulses inside an external request.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } src_e;
endpackage

// File: rtl/thr_sync.sv
module thr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/thr_mask.sv
module thr_mask #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_i,
  output logic mask_o
);
  logic [DEPTH-1:0] hist_q;
  logic [DEPTH-1:0] hist_d;

  generate
    if (DEPTH == 1) begin : g_one
      always_comb hist_d = drive_i;
    end else begin : g_many
      always_comb hist_d = {hist_q[DEPTH-2:0], drive_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign mask_o = drive_i | (|hist_q);
endmodule

// File: rtl/thr_core.sv
module thr_core
  import thermal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sensor_i,
  input  logic en_i,
  input  logic line_low_i,
  input  logic mask_i,
  output logic drive_o,
  output logic thr_o,
  output src_e src_o
);
  logic drive_q, drive_d;
  logic ext_lat_q, ext_lat_d;
  logic thr_q, thr_d;
  src_e src_q, src_d;
  logic src_ld;

  always_comb begin
    drive_d   = sensor_i;
    ext_lat_d = en_i & line_low_i & (ext_lat_q | ~mask_i);
    thr_d     = en_i & (drive_q | ext_lat_d);
    src_ld    = thr_d & ~thr_q;
    src_d     = drive_q ? SRC_INT : SRC_EXT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q   <= 1'b0;
      ext_lat_q <= 1'b0;
      thr_q     <= 1'b0;
      src_q     <= SRC_INT;
    end else begin
      drive_q   <= drive_d;
      ext_lat_q <= ext_lat_d;
      thr_q     <= thr_d;
      if (src_ld) src_q <= src_d;
    end
  end

  assign drive_o = drive_q;
  assign thr_o   = thr_q;
  assign src_o   = src_q;

  assert_drive_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> drive_q == $past(sensor_i));
  assert_no_thr_wo_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !thr_q);
  assert_ext_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !line_low_i |=> !ext_lat_q);
  assert_no_self_trigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i && !ext_lat_q) |=> !ext_lat_q);
  assert_src_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(thr_q) |-> $stable(src_q));
  assert_src_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thr_q) |-> (src_q == ($past(drive_q) ? SRC_INT : SRC_EXT)));
endmodule

// File: rtl/thermal_throttle.sv
module thermal_throttle
  import thermal_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sensor_hot_i,
  input  logic tcc_enable_i,
  input  logic hot_line_i,
  output logic hot_drive_o,
  output logic throttle_o,
  output logic cause_ext_o
);
  localparam int MASK_DEPTH = SYNC_STAGES;

  logic line_sync;
  logic line_low;
  logic mask;
  logic drive;
  logic thr;
  src_e src;

  thr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(hot_line_i), .q_o(line_sync)
  );

  assign line_low = ~line_sync;

  thr_mask #(.DEPTH(MASK_DEPTH)) u_mask (
    .clk(clk), .rst_n(rst_n), .drive_i(drive), .mask_o(mask)
  );

  thr_core u_core (
    .clk(clk), .rst_n(rst_n),
    .sensor_i(sensor_hot_i), .en_i(tcc_enable_i),
    .line_low_i(line_low), .mask_i(mask),
    .drive_o(drive), .thr_o(thr), .src_o(src)
  );

  assign hot_drive_o = drive;
  assign throttle_o  = thr;
  assign cause_ext_o = (src == SRC_EXT);
endmodule

// File: tb/sim_thermal_throttle.sv
module sim_thermal_throttle;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sensor = 1'b0;
  logic en = 1'b0;
  logic sys_pull = 1'b0;
  logic hot_line;
  logic drive, thr, cause;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  assign hot_line = ~(drive | sys_pull);

  thermal_throttle u0 (
    .clk(clk), .rst_n(rst_n), .sensor_hot_i(sensor), .tcc_enable_i(en),
    .hot_line_i(hot_line), .hot_drive_o(drive), .throttle_o(thr),
    .cause_ext_o(cause)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1", "drive", drive, 1'b0);
    chk("R1", "throttle", thr, 1'b0);
    chk("R1", "cause", cause, 1'b0);
  endtask

  task automatic t_internal();
    en = 1'b1; sensor = 1'b1;
    step(1);
    chk("R2", "drive on", drive, 1'b1);
    chk("R3", "throttle not yet", thr, 1'b0);
    step(1);
    chk("R3", "throttle on", thr, 1'b1);
    chk("R8", "cause internal", cause, 1'b0);
    sensor = 1'b0;
    step(1);
    chk("R2", "drive off", drive, 1'b0);
    chk("R3", "throttle still on", thr, 1'b1);
    step(1);
    chk("R3", "throttle off", thr, 1'b0);
    step(4);
    chk("R7", "no false external", thr, 1'b0);
    chk("R7", "cause stays internal", cause, 1'b0);
  endtask

  task automatic t_no_enable();
    en = 1'b0; sensor = 1'b1;
    step(2);
    chk("R2", "drive without enable", drive, 1'b1);
    chk("R6", "no throttle without enable", thr, 1'b0);
    sensor = 1'b0;
    step(4);
    chk("R6", "still no throttle", thr, 1'b0);
  endtask

  task automatic t_external();
    en = 1'b1; sys_pull = 1'b1;
    step(2);
    chk("R4", "throttle not yet", thr, 1'b0);
    step(1);
    chk("R4", "throttle on", thr, 1'b1);
    chk("R8", "cause external", cause, 1'b1);
    chk("R4", "no drive", drive, 1'b0);
    step(10);
    chk("R5", "held while line low", thr, 1'b1);
    sys_pull = 1'b0;
    step(2);
    chk("R5", "still on in sync delay", thr, 1'b1);
    step(1);
    chk("R5", "released", thr, 1'b0);
    step(2);
  endtask

  task automatic t_enable_drop();
    en = 1'b1; sys_pull = 1'b1;
    step(3);
    chk("R4", "throttle on before drop", thr, 1'b1);
    en = 1'b0;
    step(1);
    chk("R6", "enable cleared stops throttle", thr, 1'b0);
    sys_pull = 1'b0;
    step(5);
    en = 1'b1;
    step(3);
    chk("R6", "no throttle after re-enable", thr, 1'b0);
  endtask

  task automatic t_ext_then_sensor();
    en = 1'b1; sys_pull = 1'b1;
    step(3);
    chk("R9", "external throttle on", thr, 1'b1);
    sensor = 1'b1;
    step(2);
    chk("R9", "drive on inside request", drive, 1'b1);
    chk("R9", "throttle on", thr, 1'b1);
    sensor = 1'b0;
    step(5);
    chk("R9", "throttle kept after own release", thr, 1'b1);
    chk("R8", "cause held external", cause, 1'b1);
    sys_pull = 1'b0;
    step(3);
    chk("R5", "released after line high", thr, 1'b0);
    step(2);
  endtask

  task automatic t_cause_back();
    en = 1'b1; sensor = 1'b1;
    step(2);
    chk("R8", "cause reloads internal", cause, 1'b0);
    sensor = 1'b0;
    step(2);
    chk("R3", "throttle off", thr, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_internal();
    t_no_enable();
    t_external();
    t_enable_drop();
    t_ext_then_sensor();
    t_cause_back();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule